// File: doc/BRIEF.md
# Cascade Register Stack

This block is an eight-entry on-chip stack built from a column of registers whose top sits at a fixed slot, index 0. A push moves every stored word one slot toward the bottom and places the new word in slot 0. A pop moves every word one slot toward the top, so the old top word leaves the stack. The slot freed at the bottom is refilled, under control of a mode input, either with a copy of its previous value or with zero. No stack pointer exists. The words move and the top slot stays where it is.

The same registers can be used as a flat register file. An index port reads any slot combinationally and writes any slot in a cycle with no stack operation. An occupancy counter saturates at 0 and at the depth. It drives full and empty outputs and two sticky error flags. The overflow flag records a push onto a full stack, and the underflow flag records a pop from an empty one. The top word is also available on a registered output.

Top module: `cascade_stack`

## Requirements
- R1: When `push_i` is high at a rising edge, slot 0 takes `push_data_i`, each slot k takes the old value of slot k-1, and `tos_o` shows the new slot 0 value after that same edge.
- R2: When `pop_i` is high and `push_i` is low at a rising edge, each slot k takes the old value of slot k+1, so the old top word is gone, and `tos_o` shows the new slot 0 after that edge.
- R3: A push while the count equals 8 drops the old bottom word, leaves the count at 8 and sets `ovf_o`.
- R4: A pop while the count is 0 still shifts the slots, leaves the count at 0 and sets `unf_o`.
- R5: On a pop, slot 7 keeps its own previous value when `fill_zero_i` is 0 and becomes zero when `fill_zero_i` is 1.
- R6: When `push_i` and `pop_i` are both high, only the push takes effect.
- R7: `idx_rdata_o` always shows the slot selected by `idx_addr_i`, where index 0 is the top and index 7 is the bottom.
- R8: With no push or pop, `idx_wr_i` writes `idx_wdata_i` into slot `idx_addr_i` at the edge and leaves the count unchanged. A write to index 0 appears on `tos_o` after that edge.
- R9: An indexed write in a cycle with a push or a pop is discarded, and the stack operation alone is applied.
- R10: `ovf_o` and `unf_o` stay set until a cycle with `flag_clr_i` high and no new error of the same kind. If a new error and a clear come in the same cycle, the error wins.
- R11: While `rst_n` is low at a rising edge, all slots, `tos_o` and the count become 0 and both flags clear.
- R12: `full_o` is high exactly when the count is 8, and `empty_o` is high exactly when the count is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| push_i | input | 1 | Push request |
| pop_i | input | 1 | Pop request |
| push_data_i | input | WIDTH | Word to push |
| fill_zero_i | input | 1 | Pop refill mode: 1 zero, 0 copy bottom |
| idx_addr_i | input | IDXW | Slot index for read and write |
| idx_wr_i | input | 1 | Indexed write request |
| idx_wdata_i | input | WIDTH | Indexed write data |
| flag_clr_i | input | 1 | Clear sticky error flags |
| idx_rdata_o | output | WIDTH | Combinational read of the indexed slot |
| tos_o | output | WIDTH | Registered top-of-stack word |
| count_o | output | CNTW | Occupancy, 0 to 8 |
| full_o | output | 1 | Count equals 8 |
| empty_o | output | 1 | Count equals 0 |
| ovf_o | output | 1 | Sticky overflow flag |
| unf_o | output | 1 | Sticky underflow flag |

## Verification
A shift that goes the wrong way or skips a slot shows on `tos_o` one edge after the push or pop that caused it. The same fault shows at once on `idx_rdata_o` for any index read after that edge. A wrong bottom refill stays hidden until enough pops bring that slot to the top, so the bench reads slot 7 directly right after each pop. A counter that drifts shows first on `count_o`. A counter that drifts while saturated shows on the flags only at the next push or pop, so the bench drives the stack past both limits and checks the flags there.

// File: rtl/cstk_pkg.sv
// Shared types for the cascade register stack.
// Assumes: one operation is chosen per cycle by the top-level decoder.
package cstk_pkg;
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_PUSH  = 2'd1,
        OP_POP   = 2'd2,
        OP_WRITE = 2'd3
    } stk_op_e;
endpackage

// File: rtl/cstk_shift_array.sv
// Column of DEPTH registers with a fixed top at slot 0.
// Push shifts toward the bottom, pop shifts toward the top and refills the bottom slot.
// An indexed write touches one slot only when op is OP_WRITE.
// Assumes: DEPTH >= 2 and op already resolved by priority.
module cstk_shift_array
    import cstk_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int DEPTH = 8,
    localparam int IDXW = $clog2(DEPTH)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  stk_op_e                      op,
    input  logic                         fill_zero,
    input  logic [WIDTH-1:0]             push_data,
    input  logic [IDXW-1:0]              wr_idx,
    input  logic [WIDTH-1:0]             wr_data,
    output logic [DEPTH-1:0][WIDTH-1:0]  slots_o,
    output logic [WIDTH-1:0]             next_top_o
);
    logic [DEPTH-1:0][WIDTH-1:0] slot_q;
    logic [DEPTH-1:0][WIDTH-1:0] slot_d;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [WIDTH-1:0] from_above;
        logic [WIDTH-1:0] from_below;

        if (g == 0) begin : g_top
            assign from_above = push_data;
        end else begin : g_mid_up
            assign from_above = slot_q[g-1];
        end

        if (g == DEPTH - 1) begin : g_bottom
            assign from_below = fill_zero ? '0 : slot_q[g];
        end else begin : g_mid_dn
            assign from_below = slot_q[g+1];
        end

        // Selects the next value of this slot from the current operation.
        always_comb begin
            unique case (op)
                OP_PUSH:  slot_d[g] = from_above;
                OP_POP:   slot_d[g] = from_below;
                OP_WRITE: slot_d[g] = (wr_idx == IDXW'(g)) ? wr_data : slot_q[g];
                default:  slot_d[g] = slot_q[g];
            endcase
        end
    end

    // Registers the whole column, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign slots_o    = slot_q;
    assign next_top_o = slot_d[0];

    assert_push_loads_top_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_PUSH) |=> (slot_q[0] == $past(push_data)));
    assert_push_drops_bottom_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_PUSH) |=> (slot_q[DEPTH-1] == $past(slot_q[DEPTH-2])));
    assert_pop_moves_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_POP) |=> (slot_q[0] == $past(slot_q[1])));
    assert_zero_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_POP && fill_zero) |=> (slot_q[DEPTH-1] == '0));
    assert_copy_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_POP && !fill_zero) |=> $stable(slot_q[DEPTH-1]));
endmodule

// File: rtl/cstk_occupancy.sv
// Saturating occupancy counter with full/empty outputs and sticky error flags.
// Assumes: op is the resolved stack operation; OP_WRITE and OP_HOLD leave the count alone.
module cstk_occupancy
    import cstk_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  stk_op_e         op,
    input  logic            flag_clr,
    output logic [CNTW-1:0] count_o,
    output logic            full_o,
    output logic            empty_o,
    output logic            ovf_o,
    output logic            unf_o
);
    localparam logic [CNTW-1:0] MAXC = CNTW'(DEPTH);

    logic [CNTW-1:0] cnt_q;
    logic            ovf_q, unf_q;
    logic            is_full, is_empty, ovf_hit, unf_hit;

    assign is_full  = (cnt_q == MAXC);
    assign is_empty = (cnt_q == '0);
    assign ovf_hit  = (op == OP_PUSH) && is_full;
    assign unf_hit  = (op == OP_POP) && is_empty;

    // Steps the count up on push and down on pop, saturating at both ends.
    always_ff @(posedge clk) begin
        if (!rst_n)                            cnt_q <= '0;
        else if (op == OP_PUSH && !is_full)    cnt_q <= cnt_q + 1'b1;
        else if (op == OP_POP && !is_empty)    cnt_q <= cnt_q - 1'b1;
    end

    // Holds each error flag until cleared; a fresh error beats the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
        end else begin
            ovf_q <= ovf_hit | (ovf_q & ~flag_clr);
            unf_q <= unf_hit | (unf_q & ~flag_clr);
        end
    end

    assign count_o = cnt_q;
    assign full_o  = is_full;
    assign empty_o = is_empty;
    assign ovf_o   = ovf_q;
    assign unf_o   = unf_q;

    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= MAXC);
    assert_overflow_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_PUSH && is_full) |=> (ovf_q && cnt_q == MAXC));
    assert_underflow_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_POP && is_empty) |=> (unf_q && cnt_q == '0));
    assert_count_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_HOLD || op == OP_WRITE) |=> $stable(cnt_q));
    assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !flag_clr) |=> ovf_q);
    assert_unf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (unf_q && !flag_clr) |=> unf_q);
endmodule

// File: rtl/cascade_stack.sv
// Top of the cascade register stack: decodes requests with push over pop over
// indexed write, and holds a registered copy of the top slot.
// Assumes: requests are synchronous to clk; reset is synchronous, active low.
module cascade_stack
    import cstk_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int DEPTH = 8,
    localparam int IDXW = $clog2(DEPTH),
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic [WIDTH-1:0] push_data_i,
    input  logic             fill_zero_i,
    input  logic [IDXW-1:0]  idx_addr_i,
    input  logic             idx_wr_i,
    input  logic [WIDTH-1:0] idx_wdata_i,
    input  logic             flag_clr_i,
    output logic [WIDTH-1:0] idx_rdata_o,
    output logic [WIDTH-1:0] tos_o,
    output logic [CNTW-1:0]  count_o,
    output logic             full_o,
    output logic             empty_o,
    output logic             ovf_o,
    output logic             unf_o
);
    stk_op_e                     op;
    logic [DEPTH-1:0][WIDTH-1:0] slots;
    logic [WIDTH-1:0]            next_top;
    logic [WIDTH-1:0]            tos_q;

    // Resolves one operation per cycle: push, then pop, then indexed write.
    always_comb begin
        if (push_i)        op = OP_PUSH;
        else if (pop_i)    op = OP_POP;
        else if (idx_wr_i) op = OP_WRITE;
        else               op = OP_HOLD;
    end

    cstk_shift_array #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .op         (op),
        .fill_zero  (fill_zero_i),
        .push_data  (push_data_i),
        .wr_idx     (idx_addr_i),
        .wr_data    (idx_wdata_i),
        .slots_o    (slots),
        .next_top_o (next_top)
    );

    cstk_occupancy #(.DEPTH(DEPTH)) u_occ (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .flag_clr (flag_clr_i),
        .count_o  (count_o),
        .full_o   (full_o),
        .empty_o  (empty_o),
        .ovf_o    (ovf_o),
        .unf_o    (unf_o)
    );

    // Keeps a registered copy of the top slot for the output.
    always_ff @(posedge clk) begin
        if (!rst_n) tos_q <= '0;
        else        tos_q <= next_top;
    end

    assign tos_o       = tos_q;
    assign idx_rdata_o = slots[idx_addr_i];

    assert_tos_tracks_top_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tos_q == slots[0]);
    assert_push_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i) |=> (tos_q == $past(push_data_i)));
    assert_idx_write_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_wr_i && !push_i && !pop_i) |=> (slots[$past(idx_addr_i)] == $past(idx_wdata_i)));
    assert_idx_write_dropped_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_wr_i && pop_i && !push_i) |=> (slots[0] == $past(slots[1])));
endmodule

// File: tb/test_cascade_stack.sv
// Self-checking bench: a vector table walked by one loop, then directed corner tests.
module test_cascade_stack;
    localparam int CLK_PERIOD = 10;
    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          push_i = 1'b0, pop_i = 1'b0, fill_zero_i = 1'b0;
    logic [W-1:0]  push_data_i = '0;
    logic [2:0]    idx_addr_i = '0;
    logic          idx_wr_i = 1'b0;
    logic [W-1:0]  idx_wdata_i = '0;
    logic          flag_clr_i = 1'b0;
    logic [W-1:0]  idx_rdata_o, tos_o;
    logic [3:0]    count_o;
    logic          full_o, empty_o, ovf_o, unf_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cascade_stack i_cascade_stack (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
        .push_data_i(push_data_i), .fill_zero_i(fill_zero_i),
        .idx_addr_i(idx_addr_i), .idx_wr_i(idx_wr_i), .idx_wdata_i(idx_wdata_i),
        .flag_clr_i(flag_clr_i), .idx_rdata_o(idx_rdata_o), .tos_o(tos_o),
        .count_o(count_o), .full_o(full_o), .empty_o(empty_o),
        .ovf_o(ovf_o), .unf_o(unf_o)
    );

    typedef struct packed {
        logic        push;
        logic        pop;
        logic        fz;
        logic [31:0] din;
        logic [31:0] etos;
        logic [3:0]  ecnt;
    } vec_t;

    // Each row: push, pop, zero fill, data, expected top, expected count.
    localparam vec_t VEC [12] = '{
        '{1'b1, 1'b0, 1'b0, 32'd11, 32'd11, 4'd1},  // R1
        '{1'b1, 1'b0, 1'b0, 32'd22, 32'd22, 4'd2},  // R1
        '{1'b1, 1'b0, 1'b0, 32'd33, 32'd33, 4'd3},  // R1
        '{1'b0, 1'b1, 1'b0, 32'd0,  32'd22, 4'd2},  // R2
        '{1'b0, 1'b1, 1'b0, 32'd0,  32'd11, 4'd1},  // R2
        '{1'b1, 1'b0, 1'b0, 32'd44, 32'd44, 4'd2},  // R1
        '{1'b1, 1'b1, 1'b0, 32'd55, 32'd55, 4'd3},  // R6
        '{1'b0, 1'b1, 1'b1, 32'd0,  32'd44, 4'd2},  // R2
        '{1'b0, 1'b1, 1'b0, 32'd0,  32'd11, 4'd1},  // R2
        '{1'b0, 1'b1, 1'b0, 32'd0,  32'd0,  4'd0},  // R2
        '{1'b0, 1'b1, 1'b0, 32'd0,  32'd0,  4'd0},  // R4
        '{1'b0, 1'b0, 1'b0, 32'd0,  32'd0,  4'd0}   // R12
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drives one request at the falling edge, waits for the rising edge, then idles.
    task automatic cycle(input logic ps, input logic pp, input logic fz, input logic [31:0] d,
                         input logic iw, input logic [2:0] ia, input logic [31:0] id,
                         input logic clr);
        @(negedge clk);
        push_i = ps; pop_i = pp; fill_zero_i = fz; push_data_i = d;
        idx_wr_i = iw; idx_addr_i = ia; idx_wdata_i = id; flag_clr_i = clr;
        @(posedge clk);
        #1;
        push_i = 1'b0; pop_i = 1'b0; idx_wr_i = 1'b0; flag_clr_i = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a);
        idx_addr_i = a;
        #1;
    endtask

    initial begin
        for (int n = 0; n < 5000; n++) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R11 reset state
        check("R11 tos", tos_o, 0);
        check("R11 count", 32'(count_o), 0);
        check("R11 flags", {30'd0, ovf_o, unf_o}, 0);
        check("R12 empty", 32'(empty_o), 1);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < 12; i++) begin
            cycle(VEC[i].push, VEC[i].pop, VEC[i].fz, VEC[i].din, 1'b0, 3'd0, 32'd0, 1'b0);
            check($sformatf("R1/R2/R6 tos row %0d", i), tos_o, VEC[i].etos);
            check($sformatf("R3/R4 count row %0d", i), 32'(count_o), 32'(VEC[i].ecnt));
        end

        // R4 underflow flagged, R10 cleared by flag_clr
        check("R4 unf", 32'(unf_o), 1);
        cycle(1'b0, 1'b0, 1'b0, 0, 1'b0, 3'd0, 0, 1'b1);
        check("R10 unf clear", 32'(unf_o), 0);

        // R3 overflow: push 1..9 loses the word 1
        for (int v = 1; v <= 9; v++) cycle(1'b1, 1'b0, 1'b0, 32'(v), 1'b0, 3'd0, 0, 1'b0);
        check("R3 count sat", 32'(count_o), 8);
        check("R3 ovf", 32'(ovf_o), 1);
        check("R12 full", 32'(full_o), 1);
        peek(3'd7);
        check("R3 bottom lost", idx_rdata_o, 2);
        peek(3'd0);
        check("R7 top index", idx_rdata_o, 9);

        // R5 copy fill keeps bottom value
        cycle(1'b0, 1'b1, 1'b0, 0, 1'b0, 3'd7, 0, 1'b0);
        peek(3'd7);
        check("R5 copy fill", idx_rdata_o, 2);
        check("R10 ovf sticky", 32'(ovf_o), 1);
        for (int k = 0; k < 6; k++) cycle(1'b0, 1'b1, 1'b0, 0, 1'b0, 3'd7, 0, 1'b0);
        check("R2 tos after pops", tos_o, 2);
        check("R2 count", 32'(count_o), 1);

        // R5 zero fill
        cycle(1'b0, 1'b1, 1'b1, 0, 1'b0, 3'd7, 0, 1'b0);
        peek(3'd7);
        check("R5 zero fill", idx_rdata_o, 0);

        // R8 indexed write
        cycle(1'b0, 1'b0, 1'b0, 0, 1'b1, 3'd3, 32'hABCD, 1'b0);
        peek(3'd3);
        check("R8 idx write", idx_rdata_o, 32'hABCD);
        check("R8 count unchanged", 32'(count_o), 0);

        // R9 write with push is dropped
        cycle(1'b1, 1'b0, 1'b0, 32'h77, 1'b1, 3'd5, 32'hDEAD, 1'b0);
        peek(3'd5);
        check("R9 write dropped", idx_rdata_o, 2);
        peek(3'd4);
        check("R1 shifted slot", idx_rdata_o, 32'hABCD);
        check("R1 tos", tos_o, 32'h77);

        // R8 write to index 0 reaches tos
        cycle(1'b0, 1'b0, 1'b0, 0, 1'b1, 3'd0, 32'h1234, 1'b0);
        check("R8 tos via index", tos_o, 32'h1234);

        // R10 error beats clear; count is 1, so fill to 8 then push with clear
        for (int v = 0; v < 7; v++) cycle(1'b1, 1'b0, 1'b0, 32'(v), 1'b0, 3'd0, 0, 1'b0);
        cycle(1'b1, 1'b0, 1'b0, 32'h5, 1'b0, 3'd0, 0, 1'b1);
        check("R10 set wins", 32'(ovf_o), 1);
        cycle(1'b0, 1'b0, 1'b0, 0, 1'b0, 3'd0, 0, 1'b1);
        check("R10 ovf clear", 32'(ovf_o), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule